// File: doc/BRIEF.md
# Watermark Queue with Selectable Interrupt Source

This block is one hardware queue of data words kept in an internal buffer. Software sets it up through a single 32-bit configuration word. That word chooses the buffer length, the number of words that make up one entry, and two watermark codes. A producer pushes one word per cycle through the access port and a consumer pops one word per cycle. The queue reports four level flags: empty, nearly empty, nearly full and full. It also keeps two sticky error flags, one for underflow and one for overflow.

A 3-bit source select chooses which of eight conditions raises the queue's interrupt. Each condition is tied to the kind of access that came before it, a read or a write. The block tests the chosen condition in the cycle after each push or pop request, and never while the queue is idle. A hit is recorded in a sticky pending bit, but only while the enable input is high. Software clears the pending bit and the error flags by writing ones to a clear mask.

Top module: `wm_queue`

## Requirements
- R1: After reset, q_status reads 0x3 (bit 0 empty and bit 1 nearly empty set, bit 2 nearly full and bit 3 full clear), err_flags is 0, cfg_rdata is 0 and irq_pending is 0.
- R2: Words leave the queue in the order they were pushed. The word for a pop request sampled at one clock edge appears on pop_data after that edge. A push and a pop may be accepted in the same cycle.
- R3: The configuration word holds the buffer-size code in bits 25:24, giving 16 shifted left by the code words (16, 32, 64 or 128). Reading it back returns the write pointer in bits 6:0 and the read pointer in bits 13:7. Both pointers wrap at the buffer length.
- R4: The entry-size code in bits 23:22 sets the words per entry: 1 for code 0, 2 for code 1, and 4 for codes 2 and 3. The level flags count whole entries only. Empty means fewer than one entry is stored, and full means fewer than one entry of space is free.
- R5: The nearly-empty code sits in bits 28:26 and the nearly-full code in bits 31:29. Code c gives a threshold of 0 when c is 0 and 2^(c-1) entries otherwise. Nearly empty holds while stored entries are at or below its threshold. Nearly full holds while free entries are at or below its threshold.
- R6: A pop while zero words are stored returns 0 on pop_data, leaves both pointers unchanged, and sets err_flags bit 0 (underflow).
- R7: A push while the stored word count equals the buffer length is discarded and sets err_flags bit 1 (overflow). The stored word count never exceeds the buffer length.
- R8: A clear strobe writes ones to clear: clr_mask bit 0 clears underflow, bit 1 clears overflow and bit 2 clears irq_pending. A new event in the same cycle wins over the clear.
- R9: A configuration write sets both pointers and the fill count to zero, ignores bits 21:0 of the written word, and drops any push or pop in the same cycle.
- R10: irq_sel picks the interrupt source. Read-class sources: 0 empty, 1 nearly empty, 6 not nearly full, 7 not full. Write-class sources: 2 nearly full, 3 full, 4 not empty, 5 not nearly empty. A source hits when its flag state, in the cycle after a push (write class) or pop (read class) request, matches. A hit sets irq_pending at the end of that cycle.
- R11: A source hit sets irq_pending only while irq_en is high.
- R12: With no push or pop request, no source is evaluated. Changing irq_sel while idle never raises irq_pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Configuration fields with live pointers |
| push_req | input | 1 | Push one word |
| push_data | input | DATA_W | Word to push |
| pop_req | input | 1 | Pop one word |
| pop_data | output | DATA_W | Popped word, valid the cycle after a pop |
| irq_sel | input | 3 | Interrupt source code |
| irq_en | input | 1 | Interrupt enable |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 3 | Clear mask: 0 underflow, 1 overflow, 2 pending |
| q_status | output | 4 | Level flags: 0 empty, 1 nearly empty, 2 nearly full, 3 full |
| err_flags | output | 2 | Sticky flags: 0 underflow, 1 overflow |
| irq_pending | output | 1 | Sticky interrupt status |

## Verification
The hardest state to reach from the ports is a full buffer at the largest length. That takes 128 more pushes than pops, and the overflow and full-class sources only show up there, often together with a pop in the same cycle. Random stimulus therefore runs in phases of several hundred cycles with a heavy bias toward pushes or toward pops, so each buffer length is both filled past its end and drained past empty. Configuration writes, clears and source changes are scattered among those phases. Directed steps cover partial entries, the enable gate and idle source changes.

// File: rtl/wmq_pkg.sv
package wmq_pkg;

    // Configuration fields as they sit in bits 31:22 of the configuration word.
    typedef struct packed {
        logic [2:0] nf_code;
        logic [2:0] ne_code;
        logic [1:0] bsize_code;
        logic [1:0] esize_code;
    } qcfg_t;

    // Level flags, bit 0 first: empty, nearly empty, nearly full, full.
    typedef struct packed {
        logic full;
        logic nfull;
        logic nempty;
        logic empty;
    } qstat_t;

    typedef enum logic [2:0] {
        SRC_EMPTY_RD      = 3'd0,
        SRC_NEMPTY_RD     = 3'd1,
        SRC_NFULL_WR      = 3'd2,
        SRC_FULL_WR       = 3'd3,
        SRC_NOTEMPTY_WR   = 3'd4,
        SRC_NOTNEMPTY_WR  = 3'd5,
        SRC_NOTNFULL_RD   = 3'd6,
        SRC_NOTFULL_RD    = 3'd7
    } src_sel_e;

    localparam int ERR_FLAGS = 2;

    // Watermark code to threshold in entries.
    function automatic logic [7:0] wm_threshold(input logic [2:0] code);
        if (code == 3'd0) return 8'd0;
        return 8'd1 << (code - 3'd1);
    endfunction

    // log2 of words per entry.
    function automatic logic [1:0] entry_shift(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/wmq_store.sv
module wmq_store #(
    parameter int DATA_W = 32,
    parameter int PTR_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        bsize_code,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [PTR_W:0]    fill_words,
    output logic [PTR_W:0]    size_words,
    output logic              uf_event,
    output logic              of_event
);
    localparam int DEPTH = 1 << PTR_W;
    localparam int CNT_W = PTR_W + 1;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q, wrap_mask;
    logic [CNT_W-1:0]  fill_q;
    logic              can_pop, can_push, do_pop, do_push;

    assign size_words = CNT_W'(16) << bsize_code;
    assign wrap_mask  = PTR_W'(size_words - CNT_W'(1));
    assign can_pop    = (fill_q != '0);
    assign can_push   = (fill_q != size_words);
    assign do_pop     = pop_req && !cfg_wr && can_pop;
    assign do_push    = push_req && !cfg_wr && can_push;
    assign uf_event   = pop_req && !cfg_wr && !can_pop;
    assign of_event   = push_req && !cfg_wr && !can_push;

    always_ff @(posedge clk) begin
        if (rst || cfg_wr) begin
            wr_q   <= '0;
            rd_q   <= '0;
            fill_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q + PTR_W'(1)) & wrap_mask;
            if (do_pop)  rd_q <= (rd_q + PTR_W'(1)) & wrap_mask;
            fill_q <= fill_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_data <= '0;
        end else if (pop_req && !cfg_wr) begin
            pop_data <= can_pop ? mem_q[rd_q] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= push_data;
    end

    assign wr_ptr     = wr_q;
    assign rd_ptr     = rd_q;
    assign fill_words = fill_q;

endmodule

// File: rtl/wmq_flags.sv
module wmq_flags
    import wmq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] fill_words,
    input  logic [CNT_W-1:0] size_words,
    input  qcfg_t            cfg,
    output qstat_t           stat
);
    logic [1:0]       sh;
    logic [CNT_W-1:0] fill_e, free_e;
    logic [7:0]       ne_thr, nf_thr;

    always_comb begin
        sh          = entry_shift(cfg.esize_code);
        fill_e      = fill_words >> sh;
        free_e      = (size_words - fill_words) >> sh;
        ne_thr      = wm_threshold(cfg.ne_code);
        nf_thr      = wm_threshold(cfg.nf_code);
        stat.empty  = (fill_e == '0);
        stat.full   = (free_e == '0);
        stat.nempty = (32'(fill_e) <= 32'(ne_thr));
        stat.nfull  = (32'(free_e) <= 32'(nf_thr));
    end

endmodule

// File: rtl/wmq_events.sv
module wmq_events
    import wmq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_wr,
    input  logic           push_req,
    input  logic           pop_req,
    input  qstat_t         stat,
    input  logic [2:0]     irq_sel,
    input  logic           irq_en,
    input  logic           clr_wr,
    input  logic [2:0]     clr_mask,
    input  logic           uf_event,
    input  logic           of_event,
    output logic           irq_pending,
    output logic [ERR_FLAGS-1:0] err_flags
);
    logic last_rd_q, last_wr_q, trig, pend_q;
    logic [ERR_FLAGS-1:0] err_set;

    always_comb begin
        unique case (src_sel_e'(irq_sel))
            SRC_EMPTY_RD:     trig = last_rd_q &&  stat.empty;
            SRC_NEMPTY_RD:    trig = last_rd_q &&  stat.nempty;
            SRC_NFULL_WR:     trig = last_wr_q &&  stat.nfull;
            SRC_FULL_WR:      trig = last_wr_q &&  stat.full;
            SRC_NOTEMPTY_WR:  trig = last_wr_q && !stat.empty;
            SRC_NOTNEMPTY_WR: trig = last_wr_q && !stat.nempty;
            SRC_NOTNFULL_RD:  trig = last_rd_q && !stat.nfull;
            SRC_NOTFULL_RD:   trig = last_rd_q && !stat.full;
            default:          trig = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_rd_q <= 1'b0;
            last_wr_q <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            last_rd_q <= pop_req && !cfg_wr;
            last_wr_q <= push_req && !cfg_wr;
            pend_q    <= (pend_q && !(clr_wr && clr_mask[2])) || (trig && irq_en);
        end
    end

    assign err_set = {of_event, uf_event};

    for (genvar g = 0; g < ERR_FLAGS; g++) begin : g_sticky
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst) flag_q <= 1'b0;
            else     flag_q <= (flag_q && !(clr_wr && clr_mask[g])) || err_set[g];
        end
        assign err_flags[g] = flag_q;
    end

    assign irq_pending = pend_q;

endmodule

// File: rtl/wm_queue.sv
module wm_queue
    import wmq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PTR_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    input  logic [2:0]        irq_sel,
    input  logic              irq_en,
    input  logic              clr_wr,
    input  logic [2:0]        clr_mask,
    output logic [3:0]        q_status,
    output logic [1:0]        err_flags,
    output logic              irq_pending
);
    localparam int CNT_W = PTR_W + 1;

    qcfg_t            cfg_q;
    qstat_t           stat;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] fill_words, size_words;
    logic             uf_event, of_event;
    logic             unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_wdata[21:0];

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_wr) cfg_q <= qcfg_t'(cfg_wdata[31:22]);
    end

    wmq_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) store_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .bsize_code(cfg_q.bsize_code),
        .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
        .pop_data(pop_data), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .fill_words(fill_words), .size_words(size_words),
        .uf_event(uf_event), .of_event(of_event)
    );

    wmq_flags #(.CNT_W(CNT_W)) flags_i (
        .fill_words(fill_words), .size_words(size_words), .cfg(cfg_q), .stat(stat)
    );

    wmq_events events_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .push_req(push_req), .pop_req(pop_req),
        .stat(stat), .irq_sel(irq_sel), .irq_en(irq_en), .clr_wr(clr_wr),
        .clr_mask(clr_mask), .uf_event(uf_event), .of_event(of_event),
        .irq_pending(irq_pending), .err_flags(err_flags)
    );

    assign q_status  = stat;
    assign cfg_rdata = {cfg_q, 8'h00, 7'(rd_ptr), 7'(wr_ptr)};

endmodule

// File: rtl/wm_queue_chk.sv
module wm_queue_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic             push_req,
    input logic             pop_req,
    input logic             irq_en,
    input logic             irq_pending,
    input logic [1:0]       err_flags,
    input logic [31:0]      cfg_rdata,
    input logic [CNT_W-1:0] fill_words,
    input logic [CNT_W-1:0] size_words
);
    a_r6_underflow_sets: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !cfg_wr && fill_words == '0) |=> err_flags[0]);

    a_r7_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        (push_req && !cfg_wr && fill_words == size_words) |=> err_flags[1]);

    a_r7_fill_bounded: assert property (@(posedge clk) disable iff (rst)
        fill_words <= size_words);

    a_r9_cfg_clears_ptrs: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (cfg_rdata[13:0] == 14'd0 && fill_words == '0));

    a_r11_gated_by_enable: assert property (@(posedge clk) disable iff (rst)
        (!irq_en && !irq_pending) |=> !irq_pending);

    a_r12_needs_access: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pending) |-> $past(push_req || pop_req, 2));

endmodule

bind wm_queue wm_queue_chk #(.CNT_W(PTR_W + 1)) chk_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .push_req(push_req), .pop_req(pop_req),
    .irq_en(irq_en), .irq_pending(irq_pending), .err_flags(err_flags),
    .cfg_rdata(cfg_rdata), .fill_words(fill_words), .size_words(size_words)
);

// File: tb/wm_queue_tb_top.sv
module wm_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst, cfg_wr, push_req, pop_req, irq_en, clr_wr;
    logic [31:0] cfg_wdata, push_data, cfg_rdata, pop_data;
    logic [2:0]  irq_sel, clr_mask;
    logic [3:0]  q_status;
    logic [1:0]  err_flags;
    logic        irq_pending;

    always #5 clk = ~clk;

    wm_queue dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .push_req(push_req), .push_data(push_data), .pop_req(pop_req), .pop_data(pop_data),
        .irq_sel(irq_sel), .irq_en(irq_en), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .q_status(q_status), .err_flags(err_flags), .irq_pending(irq_pending)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [31:0] m_mem [128];
    int          m_cnt, m_wp, m_rp, m_es, m_bs, m_ne, m_nf;
    bit          m_lrd, m_lwr, m_pend, m_uf, m_of, m_pd_chk;
    logic [31:0] m_pd;

    function automatic int sz();  return 16 << m_bs; endfunction
    function automatic int esh(); return (m_es >= 2) ? 2 : m_es; endfunction
    function automatic int thr(int c); return (c == 0) ? 0 : (1 << (c - 1)); endfunction

    function automatic logic [3:0] exp_stat();
        int fe;
        int fr;
        fe = m_cnt >> esh();
        fr = (sz() - m_cnt) >> esh();
        return {fr == 0, fr <= thr(m_nf), fe <= thr(m_ne), fe == 0};
    endfunction

    function automatic bit exp_trig(logic [3:0] st);
        case (irq_sel)
            3'd0: return m_lrd &&  st[0];
            3'd1: return m_lrd &&  st[1];
            3'd2: return m_lwr &&  st[2];
            3'd3: return m_lwr &&  st[3];
            3'd4: return m_lwr && !st[0];
            3'd5: return m_lwr && !st[1];
            3'd6: return m_lrd && !st[2];
            default: return m_lrd && !st[3];
        endcase
    endfunction

    function automatic logic [31:0] exp_cfg();
        return {3'(m_nf), 3'(m_ne), 2'(m_bs), 2'(m_es), 8'h00, 7'(m_rp), 7'(m_wp)};
    endfunction

    function automatic logic [31:0] mk_cfg(int es, int bs, int ne, int nf);
        return {3'(nf), 3'(ne), 2'(bs), 2'(es), 22'h0};
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_wp = 0; m_rp = 0; m_es = 0; m_bs = 0; m_ne = 0; m_nf = 0;
        m_lrd = 0; m_lwr = 0; m_pend = 0; m_uf = 0; m_of = 0; m_pd_chk = 0; m_pd = '0;
    endtask

    task automatic model_step();
        logic [3:0] st;
        bit t, dp, dq;
        if (rst) begin
            model_reset();
            return;
        end
        st = exp_stat();
        t  = exp_trig(st);
        m_pend = (m_pend && !(clr_wr && clr_mask[2])) || (t && irq_en);
        m_uf   = (m_uf && !(clr_wr && clr_mask[0])) || (pop_req && !cfg_wr && m_cnt == 0);
        m_of   = (m_of && !(clr_wr && clr_mask[1])) || (push_req && !cfg_wr && m_cnt == sz());
        if (cfg_wr) begin
            m_es = int'(cfg_wdata[23:22]); m_bs = int'(cfg_wdata[25:24]);
            m_ne = int'(cfg_wdata[28:26]); m_nf = int'(cfg_wdata[31:29]);
            m_cnt = 0; m_wp = 0; m_rp = 0; m_lrd = 0; m_lwr = 0; m_pd_chk = 0;
        end else begin
            dp = pop_req && m_cnt != 0;
            dq = push_req && m_cnt != sz();
            m_pd_chk = pop_req;
            if (pop_req) m_pd = dp ? m_mem[m_rp] : 32'h0;
            if (dp) m_rp = (m_rp + 1) % sz();
            if (dq) begin
                m_mem[m_wp] = push_data;
                m_wp = (m_wp + 1) % sz();
            end
            m_cnt = m_cnt + int'(dq) - int'(dp);
            m_lrd = pop_req;
            m_lwr = push_req;
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        if (!rst) begin
            chk("R5 level flags", 32'(q_status), 32'(exp_stat()));
            chk("R6 R7 error flags", 32'(err_flags), {30'h0, m_of, m_uf});
            chk("R10 irq pending", 32'(irq_pending), 32'(m_pend));
            chk("R3 config readback", cfg_rdata, exp_cfg());
            if (m_pd_chk) chk("R2 pop data", pop_data, m_pd);
        end
    endtask

    task automatic idle_inputs();
        cfg_wr = 0; push_req = 0; pop_req = 0; clr_wr = 0;
        cfg_wdata = '0; push_data = '0; clr_mask = '0;
    endtask

    task automatic do_push(logic [31:0] d);
        push_req = 1; push_data = d; cycle(); push_req = 0;
    endtask

    task automatic do_pop();
        pop_req = 1; cycle(); pop_req = 0;
    endtask

    task automatic do_cfg(logic [31:0] w);
        cfg_wr = 1; cfg_wdata = w; cycle(); cfg_wr = 0;
    endtask

    task automatic do_clr(logic [2:0] m);
        clr_wr = 1; clr_mask = m; cycle(); clr_wr = 0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        int unsigned push_pct;
        seed_dummy = $urandom(32'd24681);
        model_reset();
        rst = 1; irq_sel = 3'd0; irq_en = 0;
        idle_inputs();
        repeat (3) cycle();
        rst = 0;
        @(negedge clk);
        chk("R1 reset status", 32'(q_status), 32'h3);
        chk("R1 reset error flags", 32'(err_flags), 32'h0);
        chk("R1 reset config", cfg_rdata, 32'h0);
        chk("R1 reset irq", 32'(irq_pending), 32'h0);

        // Underflow from an empty queue
        do_pop();
        chk("R6 underflow flag", 32'(err_flags[0]), 32'h1);
        chk("R6 pop data zero", pop_data, 32'h0);
        chk("R6 pointers unchanged", 32'(cfg_rdata[13:0]), 32'h0);
        do_clr(3'b001);
        chk("R8 underflow cleared", 32'(err_flags), 32'h0);

        // Fill the 16-word buffer, then overflow
        for (int i = 0; i < 16; i++) do_push(32'hA000 + 32'(i));
        chk("R3 full at 16 words", 32'(q_status), 32'hC);
        chk("R3 write pointer wrapped", 32'(cfg_rdata[13:0]), 32'h0);
        do_push(32'hDEAD);
        chk("R7 overflow flag", 32'(err_flags[1]), 32'h1);
        for (int i = 0; i < 16; i++) do_pop();
        chk("R2 empty after drain", 32'(q_status[0]), 32'h1);

        // 32-word buffer pointer positions
        do_cfg(mk_cfg(0, 1, 0, 0));
        for (int i = 0; i < 20; i++) do_push(32'hB000 + 32'(i));
        for (int i = 0; i < 5; i++) do_pop();
        chk("R3 pointer fields", 32'(cfg_rdata[13:0]), {18'h0, 7'd5, 7'd20});

        // Configuration write clears pointers, low bits ignored
        do_cfg(mk_cfg(0, 0, 0, 0) | 32'h003F_FFFF);
        chk("R9 pointers cleared", cfg_rdata, 32'h0);
        chk("R9 status empty", 32'(q_status), 32'h3);

        // Four-word entries: partial entry still empty
        do_cfg(mk_cfg(2, 0, 0, 0));
        for (int i = 0; i < 3; i++) do_push(32'hC000 + 32'(i));
        chk("R4 partial entry empty", 32'(q_status), 32'h3);
        do_push(32'hC003);
        chk("R4 one whole entry", 32'(q_status), 32'h0);

        // Enable gating
        do_clr(3'b111);
        irq_sel = 3'd4; irq_en = 0;
        do_push(32'hE001);
        cycle();
        chk("R11 disabled no pending", 32'(irq_pending), 32'h0);
        irq_en = 1;
        do_push(32'hE002);
        cycle();
        chk("R11 enabled sets pending", 32'(irq_pending), 32'h1);

        // Idle source change, then a read-class source
        do_clr(3'b100);
        chk("R8 pending cleared", 32'(irq_pending), 32'h0);
        irq_sel = 3'd5;
        repeat (5) cycle();
        chk("R12 idle no trigger", 32'(irq_pending), 32'h0);
        irq_sel = 3'd7;
        do_pop();
        cycle();
        chk("R10 not full after read", 32'(irq_pending), 32'h1);
        do_clr(3'b111);

        // Constrained random phases
        push_pct = 50;
        for (int c = 0; c < 9000; c++) begin
            if (c % 400 == 0) push_pct = ($urandom % 2 == 0) ? 88 : 12;
            idle_inputs();
            if ($urandom % 300 == 0)
                begin cfg_wr = 1; cfg_wdata = $urandom; end
            push_req  = ($urandom % 100) < push_pct;
            pop_req   = ($urandom % 100) < (100 - push_pct);
            push_data = $urandom;
            if ($urandom % 20 == 0) begin clr_wr = 1; clr_mask = 3'($urandom); end
            if ($urandom % 50 == 0) irq_sel = 3'($urandom);
            if ($urandom % 50 == 0) irq_en = 1'($urandom);
            cycle();
        end
        idle_inputs();
        cycle();

        summary();
        $finish;
    end
endmodule